// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block is the control and datapath of a single DMA channel. Software loads a source address, a destination address, a byte count and a control word through a small register port. Once launched, the channel moves data one operand at a time: it reads the operand at the source address, then writes the same data to the destination address. Each bus phase waits for an acknowledge. After every completed operand the channel steps the addresses and the byte count by the operand size. When the count is used up, it raises a done flag.

The channel can be launched in two ways. Software can set a start bit. Alternatively, in external-request mode, a peripheral raises a request line, and that line must be high again before every later operand. Software can end an active channel at any time by writing one to the done bit. Control fields stay writable while the channel runs, and a new value steers the very next operand.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, every register reads zero, the channel is idle and `bus_req` is low.
- R2: Register addresses are 0 source, 1 destination, 2 byte count, 3 control, 4 status; any other address reads zero. `reg_rdata` shows the addressed register one cycle after `reg_raddr` is presented. Control bits are [1:0] operand size, [2] source step enable, [3] destination step enable, [4] external-request mode and [5] start. The start bit always reads back as zero. Status bits are [0] busy and [1] done.
- R3: Size code 0 means 1 byte, code 1 means 2 bytes, code 2 means 4 bytes and code 3 means 16 bytes. `bus_size` carries the current code during both bus phases.
- R4: After each completed operand, an address whose step enable is set advances by the operand size. An address whose step enable is clear keeps its value. The two addresses are stepped independently.
- R5: After each completed operand, the byte count drops by the operand size, saturating at zero. When it reaches zero the channel goes idle with status done=1 and busy=0.
- R6: An operand is a read phase (`bus_we`=0, address = source) followed by a write phase (`bus_we`=1, address = destination, `bus_wdata` = the data acknowledged in the read). Each phase holds its request and address until `bus_ack`.
- R7: With external-request mode off, a control write with start=1 presents the first read phase in the next cycle.
- R8: With external-request mode on, the start bit is ignored. A high `ext_req` starts the channel, and every later operand begins only while `ext_req` is high.
- R9: A launch is accepted only while status is all zero. While the channel is idle, a status write with done=0 clears done.
- R10: A launch with a byte count of zero sets done at once and issues no bus phase.
- R11: Writing status with done=1 while the channel is busy drops `bus_req` in the next cycle. The channel is left idle with done set, and the count and addresses of the unfinished operand are left unchanged.
- R12: A control write while the channel is active governs the next operand's stepping without a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | ADDR_W | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | ADDR_W | Registered read data |
| ext_req | input | 1 | External transfer request |
| bus_req | output | 1 | Bus phase request |
| bus_we | output | 1 | 1 for the write phase, 0 for the read phase |
| bus_addr | output | ADDR_W | Byte address of the current phase |
| bus_size | output | 2 | Operand size code |
| bus_wdata | output | DATA_W | Write-phase data |
| bus_rdata | input | DATA_W | Read-phase data, taken with `bus_ack` |
| bus_ack | input | 1 | Phase acknowledge |

## Verification
The bench builds the channel with its defaults: 32-bit addresses, a 16-bit count and a 128-bit data path. The data path is wide enough for a full 16-byte line, so every size code, including line operands with their full payload, is driven and compared. Counts up to 40 bytes reach the case where the count is not a multiple of the operand size and must saturate to zero. Acknowledge delays of zero to two cycles exercise the phase-hold behaviour.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_SRC  = 3'd0;
  localparam logic [REG_AW-1:0] RA_DST  = 3'd1;
  localparam logic [REG_AW-1:0] RA_CNT  = 3'd2;
  localparam logic [REG_AW-1:0] RA_CTRL = 3'd3;
  localparam logic [REG_AW-1:0] RA_STAT = 3'd4;

  localparam int CTL_INC_S = 2;
  localparam int CTL_INC_D = 3;
  localparam int CTL_EXT   = 4;
  localparam int CTL_GO    = 5;

  localparam int STAT_BUSY = 0;
  localparam int STAT_DONE = 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_RD,
    ST_WR
  } seq_state_e;

  // operand size code to byte count
  function automatic logic [4:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd1;
      2'd1:    return 5'd2;
      2'd2:    return 5'd4;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              upd,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [1:0]        size_q,
  output logic              inc_s_q,
  output logic              inc_d_q,
  output logic              ext_q,
  output logic              last_op,
  output logic              cnt_zero
);

  logic [4:0]        step;
  logic [ADDR_W-1:0] step_a;
  logic [CNT_W-1:0]  step_c;
  logic              wr_src, wr_dst, wr_cnt, wr_ctl;

  assign step   = size_bytes(size_q);
  assign step_a = ADDR_W'(step);
  assign step_c = CNT_W'(step);

  assign wr_src = wr_en && (wr_sel == RA_SRC);
  assign wr_dst = wr_en && (wr_sel == RA_DST);
  assign wr_cnt = wr_en && (wr_sel == RA_CNT);
  assign wr_ctl = wr_en && (wr_sel == RA_CTRL);

  assign last_op  = (cnt_q <= step_c);
  assign cnt_zero = (cnt_q == '0);

  // software writes win over the sequencer step in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
    end else if (wr_src) begin
      src_q <= wr_data;
    end else if (upd && inc_s_q) begin
      src_q <= src_q + step_a;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_q <= '0;
    end else if (wr_dst) begin
      dst_q <= wr_data;
    end else if (upd && inc_d_q) begin
      dst_q <= dst_q + step_a;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_cnt) begin
      cnt_q <= wr_data[CNT_W-1:0];
    end else if (upd) begin
      cnt_q <= last_op ? '0 : (cnt_q - step_c);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q  <= '0;
      inc_s_q <= 1'b0;
      inc_d_q <= 1'b0;
      ext_q   <= 1'b0;
    end else if (wr_ctl) begin
      size_q  <= wr_data[1:0];
      inc_s_q <= wr_data[CTL_INC_S];
      inc_d_q <= wr_data[CTL_INC_D];
      ext_q   <= wr_data[CTL_EXT];
    end
  end

  AST_SRC_STEP: assert property (@(posedge clk) disable iff (rst)
    (upd && inc_s_q && !wr_src) |=> (src_q == $past(src_q) + $past(step_a))); // R4
  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!inc_s_q && !wr_src) |=> $stable(src_q)); // R4
  AST_DST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!inc_d_q && !wr_dst) |=> $stable(dst_q)); // R4
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!upd && !wr_cnt) |=> $stable(cnt_q)); // R5
  AST_CNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (upd && !wr_cnt) |=> (cnt_q < $past(cnt_q))); // R5

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              ext_en,
  input  logic              ext_req,
  input  logic              cnt_zero,
  input  logic              last_op,
  input  logic              stat_wr,
  input  logic              stat_wdone,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output seq_state_e        state_q,
  output logic              busy,
  output logic              done_q,
  output logic              upd,
  output logic [DATA_W-1:0] data_q
);

  logic abort;

  assign busy  = (state_q != ST_IDLE);
  assign abort = stat_wr && stat_wdone && busy;
  assign upd   = (state_q == ST_WR) && bus_ack && !abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else if (abort) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b1;
    end else if (stat_wr && !busy) begin
      done_q <= stat_wdone;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (go && !done_q) begin
            if (cnt_zero) done_q  <= 1'b1;
            else          state_q <= ST_RD;
          end
        end
        ST_ARM: begin
          if (!ext_en || ext_req) state_q <= ST_RD;
        end
        ST_RD: begin
          if (bus_ack) state_q <= ST_WR;
        end
        ST_WR: begin
          if (bus_ack) begin
            if (last_op) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ext_en ? ST_ARM : ST_RD;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if ((state_q == ST_RD) && bus_ack) begin
      data_q <= bus_rdata;
    end
  end

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done_q)); // R5
  AST_ABORT_STOP: assert property (@(posedge clk) disable iff (rst)
    abort |=> (state_q == ST_IDLE && done_q)); // R11
  AST_RD_TO_WR: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_RD) && bus_ack && !abort) |=> (state_q == ST_WR)); // R6
  AST_ZERO_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_IDLE) && go && cnt_zero && !stat_wr) |=> (state_q == ST_IDLE)); // R10
  AST_ARM_WAITS: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_ARM) && ext_en && !ext_req && !stat_wr) |=> (state_q == ST_ARM)); // R8

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_waddr,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic [2:0]        reg_raddr,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              ext_req,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack
);

  localparam int CTL_W  = CTL_EXT + 1;
  localparam int STAT_W = STAT_DONE + 1;

  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        size_q;
  logic              inc_s_q, inc_d_q, ext_q;
  logic              last_op, cnt_zero;
  logic              upd, busy, done_q, go, sw_go, stat_wr;
  seq_state_e        state_q;
  logic [CTL_W-1:0]  ctl_view;
  logic [STAT_W-1:0] stat_view;

  assign sw_go   = reg_wr && (reg_waddr == RA_CTRL)
                   && reg_wdata[CTL_GO] && !reg_wdata[CTL_EXT];
  assign go      = sw_go || (ext_q && ext_req);
  assign stat_wr = reg_wr && (reg_waddr == RA_STAT);

  dma_seq_regs #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr),
    .wr_sel   (reg_waddr),
    .wr_data  (reg_wdata),
    .upd      (upd),
    .src_q    (src_q),
    .dst_q    (dst_q),
    .cnt_q    (cnt_q),
    .size_q   (size_q),
    .inc_s_q  (inc_s_q),
    .inc_d_q  (inc_d_q),
    .ext_q    (ext_q),
    .last_op  (last_op),
    .cnt_zero (cnt_zero)
  );

  dma_seq_fsm #(
    .DATA_W (DATA_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .ext_en     (ext_q),
    .ext_req    (ext_req),
    .cnt_zero   (cnt_zero),
    .last_op    (last_op),
    .stat_wr    (stat_wr),
    .stat_wdone (reg_wdata[STAT_DONE]),
    .bus_ack    (bus_ack),
    .bus_rdata  (bus_rdata),
    .state_q    (state_q),
    .busy       (busy),
    .done_q     (done_q),
    .upd        (upd),
    .data_q     (bus_wdata)
  );

  assign ctl_view  = {ext_q, inc_d_q, inc_s_q, size_q};
  assign stat_view = {done_q, busy};

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_raddr)
        RA_SRC:  reg_rdata <= src_q;
        RA_DST:  reg_rdata <= dst_q;
        RA_CNT:  reg_rdata <= ADDR_W'(cnt_q);
        RA_CTRL: reg_rdata <= ADDR_W'(ctl_view);
        RA_STAT: reg_rdata <= ADDR_W'(stat_view);
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign bus_req  = (state_q == ST_RD) || (state_q == ST_WR);
  assign bus_we   = (state_q == ST_WR);
  assign bus_addr = bus_we ? dst_q : src_q;
  assign bus_size = size_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack && !reg_wr) |=> (bus_req && $stable(bus_addr) && $stable(bus_we))); // R6
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> !done_q); // R5
  AST_SW_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    (sw_go && !busy && !done_q && !cnt_zero) |=> (bus_req && !bus_we)); // R7

endmodule

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;

  localparam int AW = 32;
  localparam int CW = 16;
  localparam int DW = 128;

  logic          clk = 1'b0;
  logic          rst;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_waddr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [2:0]    reg_raddr = '0;
  logic [AW-1:0] reg_rdata;
  logic          ext_req = 1'b0;
  logic          bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic          bus_ack = 1'b0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dma_chan_seq #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW)) u_dma_chan_seq (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .ext_req(ext_req), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int unsigned size_of(input int code);
    return (code == 3) ? 16 : (1 << code);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [AW-1:0] d);
    @(negedge clk);
    reg_raddr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic serve(input bit we, input logic [AW-1:0] a, input logic [1:0] sz,
                       input logic [DW-1:0] rdv, output logic [DW-1:0] wseen);
    int t = 0;
    while (!bus_req && t < 300) begin
      @(negedge clk);
      t++;
    end
    chk(bus_req == 1'b1, "R6 phase requested", DW'(bus_req), 1);
    chk(bus_we == we, "R6 phase order", DW'(bus_we), DW'(we));
    chk(bus_addr == a, "R4 phase address", DW'(bus_addr), DW'(a));
    chk(bus_size == sz, "R3 size code", DW'(bus_size), DW'(sz));
    wseen = bus_wdata;
    repeat ($urandom_range(0, 2)) @(negedge clk);
    bus_ack = 1'b1; bus_rdata = rdv;
    @(negedge clk);
    bus_ack = 1'b0;
  endtask

  task automatic run_xfer(input logic [AW-1:0] s, input logic [AW-1:0] d,
                          input int c, input int sz, input bit si, input bit di);
    int unsigned b = size_of(sz);
    int n = (c + int'(b) - 1) / int'(b);
    logic [AW-1:0] es = s, ed = d, v;
    logic [DW-1:0] rv, ws;
    wr(3'd4, '0);
    wr(3'd0, s);
    wr(3'd1, d);
    wr(3'd2, AW'(c));
    wr(3'd3, AW'((1 << 5) | (int'(di) << 3) | (int'(si) << 2) | sz));
    if (n == 0) chk(bus_req == 1'b0, "R10 no bus phase", DW'(bus_req), 0);
    else        chk(bus_req == 1'b1, "R7 launch next cycle", DW'(bus_req), 1);
    for (int k = 0; k < n; k++) begin
      rv = {$urandom, $urandom, $urandom, $urandom};
      serve(1'b0, es, 2'(sz), rv, ws);
      serve(1'b1, ed, 2'(sz), '0, ws);
      chk(ws == rv, "R6 write carries read data", ws, rv);
      if (si) es += b;
      if (di) ed += b;
    end
    rd(3'd4, v); chk(v == 2, "R5 done and not busy", DW'(v), 2);
    rd(3'd0, v); chk(v == es, "R4 final source", DW'(v), DW'(es));
    rd(3'd1, v); chk(v == ed, "R4 final destination", DW'(v), DW'(ed));
    rd(3'd2, v); chk(v == 0, "R5 count exhausted", DW'(v), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] v;
    logic [DW-1:0] ws, rv;
    void'($urandom(32'h1234abcd));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); chk(v == 0, "R1 register reset", DW'(v), 0);
    end
    chk(bus_req == 1'b0, "R1 no request", DW'(bus_req), 0);

    // R2 register port and control layout; start with external mode set is not a launch
    wr(3'd0, 32'hDEADBEEF); rd(3'd0, v); chk(v == 32'hDEADBEEF, "R2 source readback", DW'(v), 32'hDEADBEEF);
    wr(3'd3, 32'h3F); rd(3'd3, v); chk(v == 32'h1F, "R2 control readback, start reads zero", DW'(v), 32'h1F);
    chk(bus_req == 1'b0, "R8 start bit ignored in external mode", DW'(bus_req), 0);
    rd(3'd4, v); chk(v == 0, "R8 status untouched", DW'(v), 0);
    rd(3'd5, v); chk(v == 0, "R2 unmapped address", DW'(v), 0);
    wr(3'd3, 0);

    // R10 zero count launch
    run_xfer(32'h40, 32'h80, 0, 2, 1, 1);

    // R9 launch refused while done is set, then cleared
    wr(3'd2, 8);
    wr(3'd3, 32'h20);
    repeat (3) begin
      @(negedge clk); chk(bus_req == 1'b0, "R9 launch refused", DW'(bus_req), 0);
    end
    rd(3'd4, v); chk(v == 2, "R9 status kept", DW'(v), 2);
    wr(3'd4, 0); rd(3'd4, v); chk(v == 0, "R9 done cleared", DW'(v), 0);

    // R5 count not a multiple of the size
    run_xfer(32'h1000, 32'h2000, 5, 2, 1, 1);
    run_xfer(32'h3000, 32'h4000, 17, 3, 1, 0);

    // R11 stop by writing the done bit
    wr(3'd4, 0); wr(3'd0, 32'h100); wr(3'd1, 32'h200); wr(3'd2, 64);
    wr(3'd3, 32'h2C);
    serve(1'b0, 32'h100, 2'd0, 128'h55, ws);
    wr(3'd4, 2);
    chk(bus_req == 1'b0, "R11 request dropped", DW'(bus_req), 0);
    rd(3'd4, v); chk(v == 2, "R11 done after stop", DW'(v), 2);
    rd(3'd2, v); chk(v == 64, "R11 count kept", DW'(v), 64);
    rd(3'd0, v); chk(v == 32'h100, "R11 source kept", DW'(v), 32'h100);

    // R8 and R12 external request with a mid-run control change
    wr(3'd4, 0); wr(3'd0, 32'h500); wr(3'd1, 32'h600); wr(3'd2, 8);
    wr(3'd3, 32'h1D);
    repeat (4) begin
      @(negedge clk); chk(bus_req == 1'b0, "R8 waits for request", DW'(bus_req), 0);
    end
    ext_req = 1'b1;
    rv = 128'hA5A5;
    serve(1'b0, 32'h500, 2'd1, rv, ws);
    serve(1'b1, 32'h600, 2'd1, '0, ws);
    ext_req = 1'b0;
    repeat (4) begin
      @(negedge clk); chk(bus_req == 1'b0, "R8 operand waits for request", DW'(bus_req), 0);
    end
    wr(3'd3, 32'h19);
    ext_req = 1'b1;
    for (int k = 1; k < 4; k++) begin
      serve(1'b0, 32'h502, 2'd1, rv, ws);
      serve(1'b1, AW'(32'h600 + 2 * k), 2'd1, '0, ws);
    end
    ext_req = 1'b0;
    rd(3'd0, v); chk(v == 32'h502, "R12 source step stopped", DW'(v), 32'h502);
    rd(3'd1, v); chk(v == 32'h608, "R12 destination still stepping", DW'(v), 32'h608);
    rd(3'd4, v); chk(v == 2, "R8 done", DW'(v), 2);
    wr(3'd3, 0);

    // random transfers
    for (int i = 0; i < 24; i++) begin
      run_xfer($urandom, $urandom, int'($urandom_range(0, 40)),
               int'($urandom_range(0, 3)), 1'($urandom), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule